// File: doc/BRIEF.md
# Rotating-Parity Small-Write Controller

This block updates one data unit of a five-column striped array that keeps one parity unit in every stripe row. A caller presents a logical block number and the new data word with a one-cycle start strobe. The controller works out which stripe row and which disk column hold that block, and which column holds the row's parity. It then reads the old data and the old parity and writes both back: the new data, and a parity word patched by XOR.

Each disk column has its own request/done channel. The block drives a request level together with a write flag, a row address and write data. The request stays up until the disk returns a one-cycle done; on a read, the done carries the read data. The caller sees a busy level for the whole operation and a one-cycle done pulse when both writes have completed.

Top module: `raid5_rmw_ctrl`

## Requirements
- R1: After reset, busy_o and done_o are 0 and no disk request is raised.
- R2: For stripe row r = lba / 4, parity sits on column 4 - (r mod 5): column 4 in row 0, then one column lower on each following row, back to column 4 after row 4.
- R3: Within a row, data index j = lba mod 4 is given to the non-parity columns in increasing column order, so it lands on column j when j is below the parity column and on column j+1 otherwise. The row address driven to the disks is r.
- R4: An operation issues exactly one read and then exactly one write to the data column and to the parity column, and to no other column. A request stays high, with stable row and write flag, until that disk's done.
- R5: No write is raised while either read of the same operation is still outstanding.
- R6: The parity column is written with old parity XOR old data XOR new data, and the data column with the new data.
- R7: busy_o rises in the cycle after an accepted start and stays high until a single-cycle done_o, which follows the completion of both writes. busy_o is low in the cycle after done_o.
- R8: A start strobe raised while busy_o is high is ignored. No disk location other than the one addressed by the accepted operation changes.
- R9: After every operation, the XOR of the five units in the affected row is zero, provided it was zero before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a small write |
| lba_i | input | LBA_W | Logical block number |
| wdata_i | input | DATA_W | New data for the block |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| dsk_req_o | output | NCOL | Per-column request level |
| dsk_we_o | output | NCOL | Per-column write flag (1 write, 0 read) |
| dsk_row_o | output | NCOL*LBA_W | Per-column stripe row address |
| dsk_wdata_o | output | NCOL*DATA_W | Per-column write data |
| dsk_rdata_i | input | NCOL*DATA_W | Per-column read data, valid with done |
| dsk_done_i | input | NCOL | Per-column one-cycle completion |

## Verification
The assertions assume the disks behave: a done arrives only while that column's request is high, lasts one cycle, and carries valid read data. They also assume the caller keeps lba_i and wdata_i valid during the start cycle. The bench's disk model answers only outstanding requests, with a single-cycle done after a latency that differs by column and by operation, so the two reads complete in both orders. Extra start strobes are sent in the middle of operations to exercise R8.

// File: rtl/raid5_pkg.sv
package raid5_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WRITE = 2'd2,
    S_DONE  = 2'd3
  } rmw_state_e;

  // column holding parity for a given stripe row (rotates downward)
  function automatic int unsigned parity_column(input int unsigned row,
                                                input int unsigned ncol);
    return (ncol - 1) - (row % ncol);
  endfunction

  // physical column of data index idx in a row whose parity is at pcol
  function automatic int unsigned data_column(input int unsigned idx,
                                              input int unsigned pcol);
    return (idx < pcol) ? idx : idx + 1;
  endfunction

endpackage

// File: rtl/raid5_map.sv
module raid5_map
  import raid5_pkg::*;
#(
  parameter int NCOL  = 5,
  parameter int LBA_W = 12,
  parameter int COL_W = $clog2(NCOL)
) (
  input  logic [LBA_W-1:0] lba_i,
  output logic [LBA_W-1:0] row_o,
  output logic [COL_W-1:0] dcol_o,
  output logic [COL_W-1:0] pcol_o
);
  localparam int NDATA = NCOL - 1;

  int unsigned row_n, idx_n, pcol_n, dcol_n;

  always_comb begin
    row_n  = 32'(lba_i) / NDATA;
    idx_n  = 32'(lba_i) % NDATA;
    pcol_n = parity_column(row_n, NCOL);
    dcol_n = data_column(idx_n, pcol_n);
    row_o  = LBA_W'(row_n);
    pcol_o = COL_W'(pcol_n);
    dcol_o = COL_W'(dcol_n);
  end
endmodule

// File: rtl/raid5_chan.sv
module raid5_chan #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dsk_req_o,
  output logic              dsk_we_o,
  output logic [ROW_W-1:0]  dsk_row_o,
  output logic [DATA_W-1:0] dsk_wdata_o,
  input  logic [DATA_W-1:0] dsk_rdata_i,
  input  logic              dsk_done_i,
  output logic              fin_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              req_q, we_q, fin_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              accept;

  assign accept = req_q & dsk_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      fin_q   <= 1'b0;
      row_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      fin_q <= accept;
      if (accept) begin
        req_q <= 1'b0;
        if (!we_q) rdata_q <= dsk_rdata_i;
      end else if (issue_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        row_q   <= row_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign dsk_req_o   = req_q;
  assign dsk_we_o    = we_q;
  assign dsk_row_o   = row_q;
  assign dsk_wdata_o = wdata_q;
  assign fin_o       = fin_q;
  assign rdata_o     = rdata_q;

  // R4: a pending request holds its command until the disk answers
  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !dsk_done_i) |=> (req_q && $stable(we_q) && $stable(row_q) && $stable(wdata_q)));

  // R4: the sequencer never reissues on a busy channel
  p_issue_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !req_q);
endmodule

// File: rtl/raid5_seq.sv
module raid5_seq
  import raid5_pkg::*;
#(
  parameter int NCOL   = 5,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 12,
  parameter int COL_W  = $clog2(NCOL)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [ROW_W-1:0]              row_i,
  input  logic [COL_W-1:0]              dcol_i,
  input  logic [COL_W-1:0]              pcol_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NCOL-1:0]               fin_i,
  input  logic [NCOL-1:0][DATA_W-1:0]   rdata_i,
  output logic [NCOL-1:0]               issue_o,
  output logic                          issue_we_o,
  output logic [ROW_W-1:0]              issue_row_o,
  output logic [NCOL-1:0][DATA_W-1:0]   issue_wdata_o,
  output logic                          busy_o,
  output logic                          done_o
);
  function automatic logic [DATA_W-1:0] patch_parity(input logic [DATA_W-1:0] old_p,
                                                     input logic [DATA_W-1:0] old_d,
                                                     input logic [DATA_W-1:0] new_d);
    return old_p ^ old_d ^ new_d;
  endfunction

  rmw_state_e        st_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  dcol_q, pcol_q;
  logic [DATA_W-1:0] new_q;
  logic              got_d_q, got_p_q;

  logic [DATA_W-1:0] old_d, old_p, par_new;
  logic              fin_d, fin_p, have_d, have_p;
  logic              start_acc, reads_done, writes_done;

  // pick the two columns taking part in this operation
  always_comb begin
    old_d = '0;
    old_p = '0;
    fin_d = 1'b0;
    fin_p = 1'b0;
    for (int c = 0; c < NCOL; c++) begin
      if (COL_W'(c) == dcol_q) begin
        old_d = rdata_i[c];
        fin_d = fin_i[c];
      end
      if (COL_W'(c) == pcol_q) begin
        old_p = rdata_i[c];
        fin_p = fin_i[c];
      end
    end
  end

  assign have_d      = got_d_q | fin_d;
  assign have_p      = got_p_q | fin_p;
  assign start_acc   = (st_q == S_IDLE) & start_i;
  assign reads_done  = (st_q == S_READ)  & have_d & have_p;
  assign writes_done = (st_q == S_WRITE) & have_d & have_p;
  assign par_new     = patch_parity(old_p, old_d, new_q);

  always_comb begin
    issue_o       = '0;
    issue_we_o    = 1'b0;
    issue_row_o   = row_q;
    issue_wdata_o = '0;
    if (start_acc) begin
      issue_row_o = row_i;
      for (int c = 0; c < NCOL; c++)
        if (COL_W'(c) == dcol_i || COL_W'(c) == pcol_i) issue_o[c] = 1'b1;
    end else if (reads_done) begin
      issue_we_o = 1'b1;
      for (int c = 0; c < NCOL; c++) begin
        if (COL_W'(c) == dcol_q) begin
          issue_o[c]       = 1'b1;
          issue_wdata_o[c] = new_q;
        end
        if (COL_W'(c) == pcol_q) begin
          issue_o[c]       = 1'b1;
          issue_wdata_o[c] = par_new;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      row_q   <= '0;
      dcol_q  <= '0;
      pcol_q  <= '0;
      new_q   <= '0;
      got_d_q <= 1'b0;
      got_p_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q    <= S_READ;
          row_q   <= row_i;
          dcol_q  <= dcol_i;
          pcol_q  <= pcol_i;
          new_q   <= wdata_i;
          got_d_q <= 1'b0;
          got_p_q <= 1'b0;
        end
        S_READ: if (reads_done) begin
          st_q    <= S_WRITE;
          got_d_q <= 1'b0;
          got_p_q <= 1'b0;
        end else begin
          got_d_q <= have_d;
          got_p_q <= have_p;
        end
        S_WRITE: if (writes_done) begin
          st_q <= S_DONE;
        end else begin
          got_d_q <= have_d;
          got_p_q <= have_p;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);

  // R7: busy holds until done, done lasts one cycle and ends busy
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R8: a strobe during an operation leaves the latched target alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(row_q) && $stable(dcol_q) && $stable(pcol_q) && $stable(new_q)));
  // R3: data and parity never share a column
  p_cols_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (dcol_q != pcol_q));
endmodule

// File: rtl/raid5_rmw_ctrl.sv
module raid5_rmw_ctrl #(
  parameter int NCOL   = 5,
  parameter int DATA_W = 32,
  parameter int LBA_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LBA_W-1:0]       lba_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NCOL-1:0]        dsk_req_o,
  output logic [NCOL-1:0]        dsk_we_o,
  output logic [NCOL*LBA_W-1:0]  dsk_row_o,
  output logic [NCOL*DATA_W-1:0] dsk_wdata_o,
  input  logic [NCOL*DATA_W-1:0] dsk_rdata_i,
  input  logic [NCOL-1:0]        dsk_done_i
);
  localparam int COL_W = $clog2(NCOL);

  logic [LBA_W-1:0]               map_row;
  logic [COL_W-1:0]               map_dcol, map_pcol;
  logic [NCOL-1:0]                issue, fin;
  logic                           issue_we;
  logic [LBA_W-1:0]               issue_row;
  logic [NCOL-1:0][DATA_W-1:0]    issue_wdata, chan_rdata;

  raid5_map #(.NCOL(NCOL), .LBA_W(LBA_W), .COL_W(COL_W)) u_map (
    .lba_i (lba_i),
    .row_o (map_row),
    .dcol_o(map_dcol),
    .pcol_o(map_pcol)
  );

  raid5_seq #(.NCOL(NCOL), .DATA_W(DATA_W), .ROW_W(LBA_W), .COL_W(COL_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .row_i        (map_row),
    .dcol_i       (map_dcol),
    .pcol_i       (map_pcol),
    .wdata_i      (wdata_i),
    .fin_i        (fin),
    .rdata_i      (chan_rdata),
    .issue_o      (issue),
    .issue_we_o   (issue_we),
    .issue_row_o  (issue_row),
    .issue_wdata_o(issue_wdata),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_chan
    raid5_chan #(.DATA_W(DATA_W), .ROW_W(LBA_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_i    (issue[c]),
      .we_i       (issue_we),
      .row_i      (issue_row),
      .wdata_i    (issue_wdata[c]),
      .dsk_req_o  (dsk_req_o[c]),
      .dsk_we_o   (dsk_we_o[c]),
      .dsk_row_o  (dsk_row_o[c*LBA_W +: LBA_W]),
      .dsk_wdata_o(dsk_wdata_o[c*DATA_W +: DATA_W]),
      .dsk_rdata_i(dsk_rdata_i[c*DATA_W +: DATA_W]),
      .dsk_done_i (dsk_done_i[c]),
      .fin_o      (fin[c]),
      .rdata_o    (chan_rdata[c])
    );
  end

  // R5: while any write is pending, no read is pending
  p_reads_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dsk_req_o & dsk_we_o)) |-> !(|(dsk_req_o & ~dsk_we_o)));
  // R4: at most the data and parity columns are ever addressed together
  p_two_cols_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dsk_req_o) <= 2);
  // R1/R7: disks are idle whenever the controller is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dsk_req_o == '0));
endmodule

// File: tb/raid5_rmw_ctrl_bench.sv
`timescale 1ns/1ps
module raid5_rmw_ctrl_bench;
  localparam int NCOL = 5, DATA_W = 32, LBA_W = 12, ROWS = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LBA_W-1:0] lba = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic busy, done;
  logic [NCOL-1:0] dsk_req, dsk_we, dsk_done = '0;
  logic [NCOL*LBA_W-1:0] dsk_row;
  logic [NCOL*DATA_W-1:0] dsk_wdata, dsk_rdata = '0;

  always #2 clk = ~clk;

  raid5_rmw_ctrl #(.NCOL(NCOL), .DATA_W(DATA_W), .LBA_W(LBA_W)) u_raid5_rmw_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lba_i(lba), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .dsk_req_o(dsk_req), .dsk_we_o(dsk_we),
    .dsk_row_o(dsk_row), .dsk_wdata_o(dsk_wdata), .dsk_rdata_i(dsk_rdata),
    .dsk_done_i(dsk_done));

  int checks = 0, errors = 0, ops_done = 0, opnum = 0;
  logic [DATA_W-1:0] mem [NCOL][ROWS];
  logic [DATA_W-1:0] shadow [NCOL][ROWS];
  int cnt [NCOL];
  logic [NCOL-1:0] rd_mask, wr_mask;
  bit order_bad, row_bad;

  typedef struct {int row; int dcol; int pcol; logic [DATA_W-1:0] d; logic [DATA_W-1:0] p;} exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // disk model: answers outstanding requests with a one-cycle done
  always @(negedge clk) begin
    for (int c = 0; c < NCOL; c++) begin
      if (dsk_done[c]) dsk_done[c] = 1'b0;
      else if (dsk_req[c]) begin
        cnt[c]++;
        if (dsk_req & dsk_we & ~(1 << c) & ~dsk_done) begin end
        if (cnt[c] >= 1 + (c + opnum) % 4) begin
          int r;
          cnt[c] = 0;
          r = int'(dsk_row[c*LBA_W +: LBA_W]);
          if (r >= ROWS) row_bad = 1;
          else if (dsk_we[c]) begin
            if ($countones(rd_mask) != 2) order_bad = 1;
            mem[c][r] = dsk_wdata[c*DATA_W +: DATA_W];
            wr_mask[c] = 1'b1;
          end else begin
            dsk_rdata[c*DATA_W +: DATA_W] = mem[c][r];
            rd_mask[c] = 1'b1;
          end
          dsk_done[c] = 1'b1;
        end
      end
    end
    if ((|(dsk_req & dsk_we)) && (|(dsk_req & ~dsk_we))) order_bad = 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      logic [DATA_W-1:0] x;
      ops_done++;
      if (sb.size() == 0) chk(0, "R8 unexpected done", ops_done, 0);
      else begin
        e = sb.pop_front();
        chk(mem[e.dcol][e.row] == e.d, "R3/R6 data unit", mem[e.dcol][e.row], e.d);
        chk(mem[e.pcol][e.row] == e.p, "R6 parity unit", mem[e.pcol][e.row], e.p);
        x = '0;
        for (int c = 0; c < NCOL; c++) x ^= mem[c][e.row];
        chk(x == '0, "R9 row xor", x, 0);
        chk(rd_mask == ((1 << e.dcol) | (1 << e.pcol)), "R4 read columns", rd_mask, (1 << e.dcol) | (1 << e.pcol));
        chk(wr_mask == ((1 << e.dcol) | (1 << e.pcol)), "R2/R4 write columns", wr_mask, (1 << e.dcol) | (1 << e.pcol));
        chk(!order_bad, "R5 reads before writes", order_bad, 0);
        chk(!row_bad, "R3 row address", row_bad, 0);
      end
    end
  end

  // bench's own placement: walk parity down one column per row
  function automatic int pcol_of(input int row);
    int p = NCOL - 1;
    for (int k = 0; k < row; k++) p = (p == 0) ? NCOL - 1 : p - 1;
    return p;
  endfunction

  function automatic int dcol_of(input int j, input int p);
    int n = 0;
    for (int c = 0; c < NCOL; c++) if (c != p) begin
      if (n == j) return c;
      n++;
    end
    return -1;
  endfunction

  task automatic do_write(input int l, input logic [DATA_W-1:0] d, input bit stray);
    exp_t e;
    while (busy) @(negedge clk);
    e.row = l / 4;
    e.pcol = pcol_of(e.row);
    e.dcol = dcol_of(l % 4, e.pcol);
    e.d = d;
    e.p = shadow[e.pcol][e.row] ^ shadow[e.dcol][e.row] ^ d;
    shadow[e.dcol][e.row] = d;
    shadow[e.pcol][e.row] = e.p;
    sb.push_back(e);
    rd_mask = '0; wr_mask = '0; order_bad = 0; row_bad = 0;
    opnum++;
    start = 1'b1; lba = LBA_W'(l); wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (stray) begin
      @(negedge clk);
      start = 1'b1; lba = LBA_W'((l + 5) % 60); wdata = ~d;  // R8 strobe while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R7 idle after done", {busy, done}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 operation never completed");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    for (int c = 0; c < NCOL; c++) cnt[c] = 0;
    for (int r = 0; r < ROWS; r++) begin
      logic [DATA_W-1:0] acc = '0;
      for (int c = 0; c < NCOL; c++) begin
        logic [DATA_W-1:0] v = 32'h1234_5678 * (r * 7 + c + 1);
        if (c == pcol_of(r)) continue;
        mem[c][r] = v; shadow[c][r] = v; acc ^= v;
      end
      mem[pcol_of(r)][r] = acc; shadow[pcol_of(r)][r] = acc;
    end
    rd_mask = '0; wr_mask = '0; order_bad = 0; row_bad = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && dsk_req == 0, "R1 reset state", {busy, done, dsk_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dsk_req == 0 && busy == 0, "R1 idle after reset", {busy, dsk_req}, 0);
    do_write(0,  32'h0000_0000, 0);   // row 0, parity col 4, data col 0
    do_write(3,  32'hFFFF_FFFF, 1);   // row 0, data col 3
    do_write(4,  32'hA5A5_5A5A, 0);   // row 1, parity col 3, data col 0
    do_write(7,  32'h0F0F_00FF, 1);   // row 1, index 3 skips parity -> col 4
    do_write(19, 32'h1357_9BDF, 0);   // row 4, parity col 0, data col 4
    do_write(16, 32'hDEAD_BEEF, 1);   // row 4, index 0 -> col 1
    do_write(20, 32'h8000_0001, 0);   // row 5 wraps parity back to col 4
    do_write(33, 32'h7777_1111, 1);   // row 8, parity col 1
    do_write(0,  32'h2468_ACE0, 0);   // rewrite same unit
    do_write(58, 32'hCAFE_F00D, 1);   // row 14, parity col 0
    repeat (40) @(negedge clk);
    chk(ops_done == 10, "R8 done count", ops_done, 10);
    chk(busy == 0, "R8 no extra operation", busy, 0);
    begin
      int bad = 0;
      for (int c = 0; c < NCOL; c++)
        for (int r = 0; r < ROWS; r++) if (mem[c][r] !== shadow[c][r]) bad++;
      chk(bad == 0, "R8 untouched locations", bad, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule